// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a general-purpose countdown timer that raises an interrupt at an interval set by software. One configuration word holds a run/stop bit and a preload value. While the timer runs, it counts down once per tick pulse from an external prescaler. When the count reaches zero, it sets a sticky event flag. On the next tick it reloads from the stored preload value, so the event repeats every preload+1 ticks.

Software reaches the block through a small register port with three words:

- **Address 0:** the configuration word.
- **Address 1:** the live count, read-only.
- **Address 2:** interrupt control. It holds the sticky flag, which is cleared by writing 1, and an interrupt mask bit.

Stopping the timer also returns the stored preload to all ones. Software must therefore rewrite the preload after each stop. The interrupt output is the flag gated by the mask bit.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous reset: run bit 0, preload FFFFh, count 0, flag 0, mask 0, `irq_o` 0, `bus_rdata_o` 0.
- R2: Address 0 holds the run bit at bit 29 and the preload at bits 15:0. All other bits of this word read 0, and writing them has no effect.
- R3: A write to address 0 that clears bit 29 while the timer runs stops it and sets the preload to FFFFh, whatever preload the write carried. A write with bit 29 at 0 while already stopped stores the written preload.
- R4: A write that sets bit 29 while the timer is stopped loads the count with that write's preload field. A write while already running updates only the stored preload, and the count carries on.
- R5: While running, each cycle with `tick_i` high decrements the count. A tick at count 0 reloads the count from the stored preload.
- R6: While stopped, ticks are ignored and the count holds. Address 1 returns the count in bits 15:0, with the upper bits 0.
- R7: The flag sets on any running tick whose resulting count is 0. This includes every tick when the preload is 0. A set wins over a clear in the same cycle.
- R8: At address 2, bit 0 is the flag: writing 1 clears it and writing 0 leaves it unchanged. Bit 1 is the read/write mask. `irq_o` equals flag AND mask, updated on the same clock edge as those bits.
- R9: `bus_rdata_o` is registered. It captures the addressed word on an edge where `bus_rd_i` is high and holds otherwise. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request (flag AND mask) |

## Verification
The bench goes after the halt write that carries a nonzero preload. A design that stores the written value there instead of FFFFh shows the wrong preload on readback.

It checks the zero-count tick, which must reload rather than wrap to FFFFh, and a zero preload, which must flag on every tick. A design that only flags on a decrement would miss both.

A flag clear that lands on the same cycle as an expiry must leave the flag set; a design with the priority reversed loses that event. The bench also checks that ticks while stopped leave the count untouched, and that a write while running does not restart the count.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned RUN_POS  = 29;
  localparam int unsigned FLAG_POS = 0;
  localparam int unsigned MASK_POS = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG   = 2'd0,
    A_COUNT = 2'd1,
    A_IRQ   = 2'd2,
    A_NONE  = 2'd3
  } itmr_addr_e;
endpackage

// File: rtl/itmr_cfg.sv
module itmr_cfg
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cfg,
  input  logic [REG_W-1:0] wdata,
  output logic             run_q,
  output logic [CNT_W-1:0] preload_q,
  output logic             start,
  output logic [CNT_W-1:0] start_val
);
  logic run_d;
  logic halt;

  always_comb begin
    run_d     = wr_cfg ? wdata[RUN_POS] : run_q;
    halt      = wr_cfg && run_q && !wdata[RUN_POS];
    start     = wr_cfg && !run_q && wdata[RUN_POS];
    start_val = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      preload_q <= '1;
    end else begin
      run_q <= run_d;
      if (halt)        preload_q <= '1;
      else if (wr_cfg) preload_q <= wdata[CNT_W-1:0];
    end
  end

  assert_halt_preset_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && run_q && !wdata[RUN_POS]) |=> (preload_q == '1 && !run_q));

  assert_run_change_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> $stable(run_q));
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  logic [CNT_W-1:0] step;
  logic             advance;

  always_comb begin
    advance = run && tick && !start;
    step    = (count_q == '0) ? preload : count_q - 1'b1;
    expire  = advance && (step == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (start)   count_q <= start_val;
    else if (advance) count_q <= step;
  end

  assert_start_load_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> (count_q == $past(start_val)));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(count_q));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_irq,
  input  logic [REG_W-1:0] wdata,
  input  logic             expire,
  output logic             flag_q,
  output logic             mask_q,
  output logic             irq_q
);
  logic flag_d;
  logic mask_d;

  always_comb begin
    mask_d = wr_irq ? wdata[MASK_POS] : mask_q;
    if (expire)                          flag_d = 1'b1;
    else if (wr_irq && wdata[FLAG_POS])  flag_d = 1'b0;
    else                                 flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq_q  <= flag_d & mask_d;
    end
  end

  assert_event_sets_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_irq && wdata[FLAG_POS])) |=> flag_q);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !expire) |=> !flag_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                irq_o
);
  itmr_addr_e       addr;
  logic             wr_cfg, wr_irq;
  logic             run_q, start, expire, flag_q, mask_q;
  logic [CNT_W-1:0] preload_q, start_val, count_q;
  logic [REG_W-1:0] rd_word;

  assign addr   = itmr_addr_e'(bus_addr_i);
  assign wr_cfg = bus_wr_i && (addr == A_CFG);
  assign wr_irq = bus_wr_i && (addr == A_IRQ);

  itmr_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wdata(bus_wdata_i),
    .run_q(run_q), .preload_q(preload_q), .start(start), .start_val(start_val)
  );

  itmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick_i), .start(start),
    .start_val(start_val), .preload(preload_q), .count_q(count_q), .expire(expire)
  );

  itmr_irq u_irq (
    .clk(clk), .rst(rst), .wr_irq(wr_irq), .wdata(bus_wdata_i), .expire(expire),
    .flag_q(flag_q), .mask_q(mask_q), .irq_q(irq_o)
  );

  always_comb begin
    rd_word = '0;
    unique case (addr)
      A_CFG: begin
        rd_word[RUN_POS]     = run_q;
        rd_word[CNT_W-1:0]   = preload_q;
      end
      A_COUNT: rd_word[CNT_W-1:0] = count_q;
      A_IRQ: begin
        rd_word[FLAG_POS] = flag_q;
        rd_word[MASK_POS] = mask_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_word;
  end

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> $stable(bus_rdata_o));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && addr == A_CFG) |=> (bus_rdata_o[31:30] == '0 && bus_rdata_o[28:CNT_W] == '0));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_q && mask_q));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 26;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  // vector: op[71:70] addr[69:68] data[67:36] expected[35:4] req[3:0]
  localparam logic [71:0] VEC [NVEC] = '{
    {OP_RD, 2'd0, 32'h0,         32'h0000FFFF, 4'd1},
    {OP_RD, 2'd1, 32'h0,         32'h00000000, 4'd1},
    {OP_RD, 2'd2, 32'h0,         32'h00000000, 4'd1},
    {OP_WR, 2'd0, 32'h00000005,  32'h0,        4'd3},
    {OP_RD, 2'd0, 32'h0,         32'h00000005, 4'd3},
    {OP_WR, 2'd0, 32'hFFFF0003,  32'h0,        4'd2},
    {OP_RD, 2'd0, 32'h0,         32'h20000003, 4'd2},
    {OP_RD, 2'd1, 32'h0,         32'h00000003, 4'd4},
    {OP_TK, 2'd0, 32'd2,         32'h0,        4'd5},
    {OP_RD, 2'd1, 32'h0,         32'h00000001, 4'd5},
    {OP_RD, 2'd2, 32'h0,         32'h00000000, 4'd7},
    {OP_TK, 2'd0, 32'd1,         32'h0,        4'd5},
    {OP_RD, 2'd1, 32'h0,         32'h00000000, 4'd5},
    {OP_RD, 2'd2, 32'h0,         32'h00000001, 4'd7},
    {OP_TK, 2'd0, 32'd1,         32'h0,        4'd5},
    {OP_RD, 2'd1, 32'h0,         32'h00000003, 4'd5},
    {OP_WR, 2'd2, 32'h00000000,  32'h0,        4'd8},
    {OP_RD, 2'd2, 32'h0,         32'h00000001, 4'd8},
    {OP_WR, 2'd2, 32'h00000001,  32'h0,        4'd8},
    {OP_RD, 2'd2, 32'h0,         32'h00000000, 4'd8},
    {OP_WR, 2'd0, 32'h00000007,  32'h0,        4'd3},
    {OP_RD, 2'd0, 32'h0,         32'h0000FFFF, 4'd3},
    {OP_TK, 2'd0, 32'd3,         32'h0,        4'd6},
    {OP_RD, 2'd1, 32'h0,         32'h00000003, 4'd6},
    {OP_RD, 2'd3, 32'h0,         32'h00000000, 4'd9},
    {OP_RD, 2'd2, 32'h0,         32'h00000000, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  interval_timer i_interval_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk); bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk); bus_rd_i = 1'b0; d = bus_rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rdata", bus_rdata_o, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      logic [71:0] e;
      e = VEC[k];
      case (e[71:70])
        OP_WR: wr(e[69:68], e[67:36]);
        OP_TK: ticks(int'(e[67:36]));
        default: begin
          rd(e[69:68], v);
          check($sformatf("R%0d vector %0d", e[3:0], k), v, e[35:4]);
        end
      endcase
    end

    // R4: write while running updates preload only
    wr(2'd0, 32'h20000005);
    ticks(2);
    wr(2'd0, 32'h20000009);
    rd(2'd1, v); check("R4 count kept", v, 32'd3);
    ticks(3);
    rd(2'd1, v); check("R4 at zero", v, 32'd0);
    ticks(1);
    rd(2'd1, v); check("R4 reload new preload", v, 32'd9);

    // R8/R7: mask, zero preload, set beats clear
    wr(2'd2, 32'h00000003);
    wr(2'd0, 32'h00000000);
    wr(2'd0, 32'h20000000);
    check("R8 irq before event", {31'b0, irq_o}, 32'h0);
    ticks(1);
    check("R7 zero preload flags", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h00000003);
    check("R8 clear drops irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk); bus_wr_i = 1'b1; bus_addr_i = 2'd2; bus_wdata_i = 32'h3; tick_i = 1'b1;
    @(negedge clk); bus_wr_i = 1'b0; tick_i = 1'b0;
    rd(2'd2, v); check("R7 set beats clear", v, 32'h3);
    check("R8 irq with mask", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h00000000);
    check("R8 mask off gates irq", {31'b0, irq_o}, 32'h0);
    rd(2'd2, v); check("R8 flag kept when masked", v, 32'h1);

    // R9: rdata holds without a read strobe
    @(negedge clk); bus_addr_i = 2'd0;
    @(negedge clk);
    check("R9 rdata hold", bus_rdata_o, 32'h1);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(2'd0, v); check("R1 cfg after reset", v, 32'h0000FFFF);
    ticks(2);
    rd(2'd1, v); check("R1 count after reset", v, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule